// File: doc/BRIEF.md
# Threshold Limit Loader and Classifier

This block fetches the supervisory limit table of a monitoring peripheral and turns it into per-channel comparison thresholds. Every channel carries four 16-bit limit words: two for the under-voltage direction, then two for the over-voltage direction. The block reads each word as two bytes over a simple request/response register port. It then decides from the word's action-trigger flags whether the limit is a critical one or a warning one. The result is four 10-bit thresholds per channel: critical-low, warning-low, warning-high and critical-high.

A load starts by itself when reset is released, and again on any `start` pulse that arrives while the block is idle. The first limit of each direction sets both the critical slot and the warning slot. The second limit then replaces only the slot that matches its class, so neither slot is ever left undefined. If the register port reports an error, the load stops and raises `err`, and `done` stays low.

Top module: `limit_loader`

## Requirements
- R1: Each load issues exactly 4·NCH·2 byte reads (88 by default), in ascending channel order, at address 0x80 + 8·channel + 2·limit + byte. Each address is one above the previous one.
- R2: Each limit word is assembled from two bytes: the byte at the lower (even) address is bits 15:8 and is read first, and the next address gives bits 7:0.
- R3: A threshold is word bits 9:0. Word bits 11:10 do not affect any output.
- R4: A word is critical when bit 15, bit 13 or bit 12 is set. A word with only bit 14 set counts as a warning.
- R5: The first limit of a direction (limit 0 for under, limit 2 for over) is written to both the critical and the warning output of that direction, whatever its flags are.
- R6: The second limit of a direction (limit 1 for under, limit 3 for over) overwrites only the critical output if that limit is critical, and only the warning output otherwise.
- R7: A load begins automatically after reset. A `start` pulse while idle begins a new load. A `start` pulse during a load is ignored and does not add reads.
- R8: `done` rises in the cycle after the last byte is accepted, stays high until the next load begins, and at most one read is outstanding at any time.
- R9: A read error aborts the load: `err` goes high, `done` stays low, no further reads are issued, and thresholds of channels not yet reached keep their previous values. The next load clears `err`.
- R10: During reset all threshold outputs are zero and `done` and `err` are low. Outputs change only while a load is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that requests a new load while idle |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | 8 | Byte address of the read |
| rdValid | input | 1 | Read response strobe with data |
| rdErr | input | 1 | Read response strobe reporting failure |
| rdData | input | 8 | Read response byte |
| critLo | output | NCH·10 | Critical under-limit per channel, channel c at bits 10c+9:10c |
| warnLo | output | NCH·10 | Warning under-limit per channel |
| warnHi | output | NCH·10 | Warning over-limit per channel |
| critHi | output | NCH·10 | Critical over-limit per channel |
| done | output | 1 | Load finished without error |
| err | output | 1 | Last load aborted on a read error |

## Verification
The checker relies on the register port answering each request with exactly one strobe, either `rdValid` or `rdErr` and never both. That strobe never arrives unrequested and never arrives in the same cycle as the request. It also relies on `start` being a single-cycle pulse. The bench's responder model watches for a request, waits a configurable latency of one to three cycles, and then returns one strobe. Errors are injected only at a chosen address, and table contents are changed only while the block is idle.

// File: rtl/limit_loader_pkg.sv
package limit_loader_pkg;
  // Word bit positions of the trigger flags that make a limit critical.
  // Bit 14 (healthy trigger) is deliberately not part of this set.
  localparam int TRIG_RESET    = 15;
  localparam int TRIG_POWEROFF = 13;
  localparam int TRIG_SHUTDOWN = 12;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic       capHi;   // latch the upper byte of a limit word
    logic       wrWord;  // lower byte present, commit the word
    logic [1:0] slot;    // limit index within the channel (0..3)
  } lim_ctl_t;
endpackage

// File: rtl/limit_loader_ctrl.sv
module limit_loader_ctrl
  import limit_loader_pkg::*;
#(
  parameter int NCH   = 11,
  parameter int ADDRW = 8,
  parameter int BASE  = 'h80,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             rdValid,
  input  logic             rdErr,
  output logic             rdReq,
  output logic [ADDRW-1:0] rdAddr,
  output lim_ctl_t         ctl,
  output logic [CHW-1:0]   chSel,
  output logic             done,
  output logic             err
);
  localparam int LIMS   = 4;
  localparam int STRIDE = LIMS * 2;
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  typedef enum logic [1:0] {IDLE, ISSUE, AWAIT} state_t;

  state_t     state;
  logic [1:0] slot;
  logic       byteSel;
  logic       pendStart;
  logic       accept;

  assign accept = (state == AWAIT) && rdValid && !rdErr;
  assign rdReq  = (state == ISSUE);
  assign rdAddr = ADDRW'(BASE + int'(chSel) * STRIDE + int'(slot) * 2 + int'(byteSel));

  always_comb begin
    ctl.capHi  = accept && !byteSel;
    ctl.wrWord = accept && byteSel;
    ctl.slot   = slot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= IDLE;
      chSel     <= '0;
      slot      <= '0;
      byteSel   <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      pendStart <= 1'b1;
    end else begin
      case (state)
        IDLE: if (start || pendStart) begin
          state     <= ISSUE;
          chSel     <= '0;
          slot      <= '0;
          byteSel   <= 1'b0;
          done      <= 1'b0;
          err       <= 1'b0;
          pendStart <= 1'b0;
        end
        ISSUE: state <= AWAIT;
        AWAIT: begin
          if (rdErr) begin
            state <= IDLE;
            err   <= 1'b1;
          end else if (rdValid) begin
            if (!byteSel) begin
              byteSel <= 1'b1;
              state   <= ISSUE;
            end else begin
              byteSel <= 1'b0;
              if (slot != 2'd3) begin
                slot  <= slot + 2'd1;
                state <= ISSUE;
              end else begin
                slot <= '0;
                if (chSel == LAST_CH) begin
                  state <= IDLE;
                  done  <= 1'b1;
                end else begin
                  chSel <= chSel + CHW'(1);
                  state <= ISSUE;
                end
              end
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/limit_loader_dp.sv
module limit_loader_dp
  import limit_loader_pkg::*;
#(
  parameter int NCH   = 11,
  parameter int CODEW = 10,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int HIW  = CODEW - 8,
  localparam int VW   = NCH * CODEW
) (
  input  logic           clk,
  input  logic           rstN,
  input  lim_ctl_t       ctl,
  input  logic [CHW-1:0] chSel,
  input  logic [7:0]     rdData,
  output logic [VW-1:0]  critLo,
  output logic [VW-1:0]  warnLo,
  output logic [VW-1:0]  warnHi,
  output logic [VW-1:0]  critHi
);
  // Only the parts of the upper byte that matter are kept.
  logic [HIW-1:0]   hiCode;
  logic             hiCrit;
  logic [CODEW-1:0] code;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCode <= '0;
      hiCrit <= 1'b0;
    end else if (ctl.capHi) begin
      hiCode <= rdData[HIW-1:0];
      hiCrit <= rdData[TRIG_RESET-8] | rdData[TRIG_POWEROFF-8] | rdData[TRIG_SHUTDOWN-8];
    end
  end

  assign code = {hiCode, rdData};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CODEW-1:0] cl, wl, wh, ch;
    logic             hit;
    assign hit = ctl.wrWord && (chSel == CHW'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cl <= '0; wl <= '0; wh <= '0; ch <= '0;
      end else if (hit) begin
        case (ctl.slot)
          2'd0: begin cl <= code; wl <= code; end
          2'd1: if (hiCrit) cl <= code; else wl <= code;
          2'd2: begin ch <= code; wh <= code; end
          default: if (hiCrit) ch <= code; else wh <= code;
        endcase
      end
    end

    assign critLo[c*CODEW +: CODEW] = cl;
    assign warnLo[c*CODEW +: CODEW] = wl;
    assign warnHi[c*CODEW +: CODEW] = wh;
    assign critHi[c*CODEW +: CODEW] = ch;
  end
endmodule

// File: rtl/limit_loader.sv
module limit_loader
  import limit_loader_pkg::*;
#(
  parameter int NCH   = 11,
  parameter int CODEW = 10,
  parameter int ADDRW = 8,
  parameter int BASE  = 'h80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic                 rdReq,
  output logic [ADDRW-1:0]     rdAddr,
  input  logic                 rdValid,
  input  logic                 rdErr,
  input  logic [7:0]           rdData,
  output logic [NCH*CODEW-1:0] critLo,
  output logic [NCH*CODEW-1:0] warnLo,
  output logic [NCH*CODEW-1:0] warnHi,
  output logic [NCH*CODEW-1:0] critHi,
  output logic                 done,
  output logic                 err
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  lim_ctl_t       ctl;
  logic [CHW-1:0] chSel;

  limit_loader_ctrl #(.NCH(NCH), .ADDRW(ADDRW), .BASE(BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdValid(rdValid), .rdErr(rdErr),
    .rdReq(rdReq), .rdAddr(rdAddr), .ctl(ctl), .chSel(chSel),
    .done(done), .err(err)
  );

  limit_loader_dp #(.NCH(NCH), .CODEW(CODEW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .chSel(chSel), .rdData(rdData),
    .critLo(critLo), .warnLo(warnLo), .warnHi(warnHi), .critHi(critHi)
  );
endmodule

// File: rtl/limit_loader_chk.sv
module limit_loader_chk #(
  parameter int NCH   = 11,
  parameter int CODEW = 10,
  parameter int ADDRW = 8,
  parameter int BASE  = 'h80
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 rdReq,
  input logic [ADDRW-1:0]     rdAddr,
  input logic                 rdValid,
  input logic                 rdErr,
  input logic [7:0]           rdData,
  input logic [NCH*CODEW-1:0] critLo,
  input logic [NCH*CODEW-1:0] warnLo,
  input logic [NCH*CODEW-1:0] warnHi,
  input logic [NCH*CODEW-1:0] critHi,
  input logic                 done,
  input logic                 err
);
  localparam int TOP = BASE + NCH * 8;

  logic             pending;
  logic             haveLast;
  logic [ADDRW-1:0] lastAddr;
  logic             anyData;

  assign anyData = ^rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      haveLast <= 1'b0;
      lastAddr <= '0;
    end else begin
      if (rdReq) pending <= 1'b1;
      else if (rdValid || rdErr) pending <= 1'b0;
      if (rdReq) begin
        haveLast <= 1'b1;
        lastAddr <= rdAddr;
      end
    end
  end

  p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !pending);

  p_addr_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (int'(rdAddr) >= BASE) && (int'(rdAddr) < TOP));

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && haveLast && int'(rdAddr) != BASE) |-> rdAddr == lastAddr + ADDRW'(1));

  p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  p_quiet_after_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !rdReq);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (err && !start) |=> err);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  p_idle_outputs_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((done || err) && !start && !rdValid && !anyData) |=>
      ($stable(critLo) && $stable(warnLo) && $stable(warnHi) && $stable(critHi)));

  p_done_no_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !rdReq);
endmodule

bind limit_loader limit_loader_chk #(.NCH(NCH), .CODEW(CODEW), .ADDRW(ADDRW), .BASE(BASE)) u_chk (.*);

// File: tb/tb_limit_loader.sv
module tb_limit_loader;
  localparam int NCH = 11;
  localparam int CW  = 10;
  localparam int VW  = NCH * CW;
  localparam int NREAD = NCH * 8;

  typedef struct packed {
    logic [VW-1:0] cl;
    logic [VW-1:0] wl;
    logic [VW-1:0] wh;
    logic [VW-1:0] ch;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic rdReq;
  logic [7:0] rdAddr;
  logic rdValid = 1'b0;
  logic rdErr = 1'b0;
  logic [7:0] rdData = 8'h00;
  logic [VW-1:0] critLo, warnLo, warnHi, critHi;
  logic done, err;

  int total = 0;
  int bad = 0;
  int lat = 2;
  int errAddr = -1;
  int reqCount = 0;
  int addrBad = 0;
  logic [7:0] mem [256];
  exp_t expQ[$];
  exp_t lastExp;

  always #2 clk = ~clk;

  limit_loader dut (
    .clk(clk), .rstN(rstN), .start(start), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdErr(rdErr), .rdData(rdData),
    .critLo(critLo), .warnLo(warnLo), .warnHi(warnHi), .critHi(critHi),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] wordAt(input int c, input int k);
    return {mem[8'h80 + 8*c + 2*k], mem[8'h80 + 8*c + 2*k + 1]};
  endfunction

  function automatic bit isCrit(input logic [15:0] w);
    return w[15] | w[13] | w[12];
  endfunction

  // Expected thresholds from the table, per R3..R6.
  function automatic exp_t computeExp();
    exp_t e;
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] w0, w1, w2, w3;
      logic [CW-1:0] cl, wl, wh, ch;
      w0 = wordAt(c, 0); w1 = wordAt(c, 1); w2 = wordAt(c, 2); w3 = wordAt(c, 3);
      cl = w0[9:0]; wl = w0[9:0];
      if (isCrit(w1)) cl = w1[9:0]; else wl = w1[9:0];
      ch = w2[9:0]; wh = w2[9:0];
      if (isCrit(w3)) ch = w3[9:0]; else wh = w3[9:0];
      e.cl[c*CW +: CW] = cl; e.wl[c*CW +: CW] = wl;
      e.wh[c*CW +: CW] = wh; e.ch[c*CW +: CW] = ch;
    end
    return e;
  endfunction

  // pat 0: mixed flags, junk in bits 11:10; pat 1: second limits warning (bit 14 only); pat 2: all critical
  task automatic fillTable(input int pat);
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] w;
        logic [15:0] flags;
        w = 16'((c * 37 + k * 91 + pat * 211 + 5) % 1024);
        flags = 16'h0000;
        if (pat == 0) begin
          if (k == 0 || k == 2) flags = 16'hFC00;
          else begin
            case ((c + k) % 4)
              0: flags = 16'h8000;
              1: flags = 16'h4000;
              2: flags = 16'h2000;
              default: flags = 16'h1C00;
            endcase
          end
        end else if (pat == 1) flags = (k == 1 || k == 3) ? 16'h4C00 : 16'hB000;
        else flags = 16'hB000;
        w = w | flags;
        mem[8'h80 + 8*c + 2*k]     = w[15:8];
        mem[8'h80 + 8*c + 2*k + 1] = w[7:0];
      end
    end
  endtask

  // Register port responder
  initial begin
    forever begin
      @(negedge clk);
      rdValid = 1'b0;
      rdErr   = 1'b0;
      if (rdReq) begin
        int a;
        a = int'(rdAddr);
        if (a != 8'h80 + reqCount) addrBad++;
        reqCount++;
        repeat (lat) @(negedge clk);
        if (a == errAddr) rdErr = 1'b1;
        else begin
          rdValid = 1'b1;
          rdData  = mem[a];
        end
      end
    end
  end

  // Scoreboard monitor
  initial begin
    logic prevDone;
    prevDone = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && done && !prevDone) begin
        if (expQ.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          lastExp = e;
          for (int c = 0; c < NCH; c++) begin
            check(critLo[c*CW +: CW] == e.cl[c*CW +: CW], $sformatf("R5 R6 critLo ch%0d", c),
                  int'(critLo[c*CW +: CW]), int'(e.cl[c*CW +: CW]));
            check(warnLo[c*CW +: CW] == e.wl[c*CW +: CW], $sformatf("R4 R6 warnLo ch%0d", c),
                  int'(warnLo[c*CW +: CW]), int'(e.wl[c*CW +: CW]));
            check(warnHi[c*CW +: CW] == e.wh[c*CW +: CW], $sformatf("R3 R6 warnHi ch%0d", c),
                  int'(warnHi[c*CW +: CW]), int'(e.wh[c*CW +: CW]));
            check(critHi[c*CW +: CW] == e.ch[c*CW +: CW], $sformatf("R2 R5 critHi ch%0d", c),
                  int'(critHi[c*CW +: CW]), int'(e.ch[c*CW +: CW]));
          end
        end
      end
      prevDone = done;
    end
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitEnd();
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(done || err) && n < 5000);
  endtask

  task automatic runLoad(input int pat, input int latency, input bit midStart);
    fillTable(pat);
    lat = latency;
    expQ.push_back(computeExp());
    reqCount = 0;
    addrBad = 0;
    pulseStart();
    if (midStart) begin
      repeat (30) @(negedge clk);
      pulseStart();
    end
    waitEnd();
    @(negedge clk);
    check(done == 1'b1 && err == 1'b0, "R8 done after load", int'({done, err}), 2);
    check(reqCount == NREAD, "R1 R7 read count", reqCount, NREAD);
    check(addrBad == 0, "R1 R2 address order", addrBad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Reset state, R10
    fillTable(0);
    lat = 2;
    expQ.push_back(computeExp());
    repeat (4) @(negedge clk);
    check(critLo == '0 && warnLo == '0 && warnHi == '0 && critHi == '0, "R10 reset thresholds", 0, 0);
    check(done == 1'b0, "R10 reset done", int'(done), 0);
    check(err == 1'b0, "R10 reset err", int'(err), 0);
    rstN = 1'b1;
    // R7 automatic load after reset
    waitEnd();
    @(negedge clk);
    check(done == 1'b1, "R7 auto load done", int'(done), 1);
    check(reqCount == NREAD, "R1 auto read count", reqCount, NREAD);
    check(addrBad == 0, "R1 R2 auto address order", addrBad, 0);
    // R8 done holds while idle, no reads
    reqCount = 0;
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R8 done holds", int'(done), 1);
    check(reqCount == 0, "R10 no reads while idle", reqCount, 0);

    // R4 bit 14 only as warning, R7 start during load ignored
    runLoad(1, 1, 1'b1);
    runLoad(2, 3, 1'b0);
    runLoad(0, 2, 1'b1);

    // R9 error abort at channel 5, limit 1, high byte
    fillTable(1);
    errAddr = 8'h80 + 8*5 + 2;
    reqCount = 0;
    addrBad = 0;
    pulseStart();
    waitEnd();
    @(negedge clk);
    check(err == 1'b1, "R9 err raised", int'(err), 1);
    check(done == 1'b0, "R9 done low on error", int'(done), 0);
    check(reqCount == 8*5 + 3, "R9 reads until error", reqCount, 8*5 + 3);
    repeat (20) @(negedge clk);
    check(reqCount == 8*5 + 3, "R9 no reads after error", reqCount, 8*5 + 3);
    check(err == 1'b1 && done == 1'b0, "R9 err holds", int'({err, done}), 2);
    check(critHi[7*CW +: CW] == lastExp.ch[7*CW +: CW], "R9 unreached channel holds",
          int'(critHi[7*CW +: CW]), int'(lastExp.ch[7*CW +: CW]));
    check(warnLo[9*CW +: CW] == lastExp.wl[9*CW +: CW], "R9 R10 unreached channel holds",
          int'(warnLo[9*CW +: CW]), int'(lastExp.wl[9*CW +: CW]));

    // R9 recovery clears err
    errAddr = -1;
    runLoad(1, 2, 1'b0);
    check(err == 1'b0, "R9 err cleared", int'(err), 0);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R8 all loads completed", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule